// File: doc/BRIEF.md
# Byte-Serial Peripheral Port Controller

This block is a byte-wide SPI controller that a processor drives through three registers: control, status and data. A write of the data register while the block is idle loads an eight-bit frame. In master mode that write also starts a transfer. The block then produces the serial clock from the system clock through a selectable divider and shifts the frame out most significant bit first. At the same time it shifts the reply in. In slave mode the same shift register follows an external serial clock, which it samples through synchronisers.

Completion is reported by a transfer-done flag. That flag can raise an interrupt request when both the local and the global interrupt enables are high. A second flag, the collision flag, records any data-register write made while a frame is in flight. Both flags clear in one of two ways: an acknowledge pulse on the interrupt, or a status read that sees the flag set followed by an access to the data register. A low level on the select input while the block is master counts as a mode fault. A mode fault aborts the transfer, drops the block out of master mode and sets the transfer-done flag.

Register addresses: 0 is control, 1 is status, 2 is data. Control bits: bit 7 is the interrupt enable, bit 6 is the block enable, bit 2 is master mode and bits 1:0 are the rate code. Bits 5:3 are stored and read back. Status bits: bit 7 is transfer-done, bit 6 is collision and bit 0 is double speed.

Top module: `serial_port_ctl`

## Requirements
- R1: After reset the control register and the status register read 0x00, the interrupt request is low and the serial clock output is low.
- R2: Status bits 5 to 1 always read zero. Of the status bits, only bit 0 (double speed) is changed by a status write.
- R3: In master mode one frame lasts 8 x D system clocks, where D is set by {double speed, rate code}: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64. The transfer-done flag is set exactly at the end of that window.
- R4: A master frame is sent MSB first. Data out changes only on the falling edges of the serial clock, and data in is sampled on the rising edges. After the frame, the data register reads back the received byte, and the serial clock is low while idle.
- R5: The transfer-done flag (status bit 7) is set when a frame completes.
- R6: The interrupt request is high only while the transfer-done flag, control bit 7 and the global enable input are all high.
- R7: A pulse on the interrupt-acknowledge input clears the transfer-done flag.
- R8: A data register access clears the flags only if a status read that saw them set came before it. A data access with no such read leaves the flags set.
- R9: A transfer-done event that occurs between the arming status read and the data access survives that access.
- R10: A data write during a frame sets the collision flag (status bit 6) and does not disturb the frame in flight. The next arming status read and data access clear it together with the transfer-done flag.
- R11: With the block enabled and in master mode, a low select input sets the transfer-done flag, clears control bit 2 and aborts the frame, returning the serial clock low.
- R12: In slave mode with select low, the block samples the slave data input on rising edges of the external clock and drives its slave output MSB first. After eight bits it sets transfer-done, and the data register then reads the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| ss_n_i | input | 1 | Select input, active low |

## Verification
The assertions check several rules on every cycle. Reserved status bits read zero. Outgoing data holds still across each rising serial clock edge. The clock stays low whenever no frame runs. A frame end, a mode fault or a mid-frame data write always leaves the matching flag set. An acknowledge clears transfer-done, and the interrupt never rises without the global enable. Only the bench scenarios can show the exact frame length for each of the eight divisor codes, the order of the read-then-access clear sequence, and that an event arriving between the two steps survives. The same holds for the aborted frame after a fault and for a full slave-mode exchange.

// File: rtl/spi_ctl_pkg.sv
// Package: shared register addresses, control layout and the serial clock
// divisor lookup for the serial port controller.
package spi_ctl_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // Control register layout, bit 7 down to bit 0.
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic [2:0] spare;
        logic       master;
        logic [1:0] rate;
    } ctrl_t;

    // System clocks per serial clock period for a {double speed, rate} code.
    function automatic logic [7:0] sck_divisor(input logic dbl, input logic [1:0] rate);
        case ({dbl, rate})
            3'b000:  return 8'd4;
            3'b001:  return 8'd16;
            3'b010:  return 8'd64;
            3'b011:  return 8'd128;
            3'b100:  return 8'd2;
            3'b101:  return 8'd8;
            3'b110:  return 8'd32;
            default: return 8'd64;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync.sv
// Module: multi-bit input synchroniser. Each bit passes through STAGES flops.
// Assumes the bits are independent levels (no bus coherence is needed).
module spi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
// Module: serial clock half-period timer. While run is high it pulses tick
// once every D/2 system clocks, where D comes from the divisor lookup.
// Assumes the rate inputs are held stable during a frame.
module spi_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       dbl,
    input  logic [1:0] rate,
    output logic       tick
);
    import spi_ctl_pkg::*;

    localparam int HALF_W = DIV_W - 1;

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;

    assign half = HALF_W'(sck_divisor(dbl, rate) >> 1);
    assign tick = run && (cnt == half - HALF_W'(1));

    // Count system clocks within one half period of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/spi_shifter.sv
// Module: frame shift engine. In master mode it toggles the serial clock on
// each tick, samples on rising and shifts on falling edges (mode 0). In slave
// mode it follows synchronised external clock edges. Frames are MSB first.
// Assumes the slave clock and data inputs are already synchronised.
module spi_shifter #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               master,
    input  logic               start_load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               tick,
    input  logic               abort,
    input  logic               miso_i,
    input  logic               slv_sel,
    input  logic               slv_sck,
    input  logic               slv_mosi,
    output logic               busy,
    output logic               mst_run,
    output logic               done,
    output logic [FRAME_W-1:0] rx_data,
    output logic               sck_o,
    output logic               sdo
);
    localparam int                 CNT_W = $clog2(FRAME_W) + 1;
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(FRAME_W - 1);

    logic               busy_q, mst_q, sck_q, rx_bit, slv_sck_d;
    logic [FRAME_W-1:0] shreg, rxbuf;
    logic [CNT_W-1:0]   bitcnt;
    logic               slv_active, slv_rise, slv_fall;
    logic               m_rise, m_fall, sample_edge, shift_edge, last;

    assign slv_active  = slv_sel && !mst_q;
    assign slv_rise    = slv_active && slv_sck && !slv_sck_d;
    assign slv_fall    = slv_active && !slv_sck && slv_sck_d;
    assign m_rise      = busy_q && mst_q && tick && !sck_q;
    assign m_fall      = busy_q && mst_q && tick && sck_q;
    assign sample_edge = m_rise || slv_rise;
    assign shift_edge  = m_fall || slv_fall;
    assign last        = shift_edge && (bitcnt == LAST) && !abort;

    // Frame sequencing: load, clock generation, sampling, shifting, abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            mst_q     <= 1'b0;
            sck_q     <= 1'b0;
            rx_bit    <= 1'b0;
            slv_sck_d <= 1'b0;
            shreg     <= '0;
            rxbuf     <= '0;
            bitcnt    <= '0;
        end else begin
            slv_sck_d <= slv_sck;
            if (abort) begin
                busy_q <= 1'b0;
                mst_q  <= 1'b0;
                sck_q  <= 1'b0;
                bitcnt <= '0;
            end else if (start_load && !busy_q) begin
                shreg  <= load_data;
                bitcnt <= '0;
                if (en && master) begin
                    busy_q <= 1'b1;
                    mst_q  <= 1'b1;
                    sck_q  <= 1'b0;
                end
            end else begin
                if (m_rise) sck_q <= 1'b1;
                if (m_fall) sck_q <= 1'b0;
                if (sample_edge) begin
                    rx_bit <= mst_q ? miso_i : slv_mosi;
                    if (!mst_q) busy_q <= 1'b1;
                end
                if (shift_edge) begin
                    shreg <= {shreg[FRAME_W-2:0], rx_bit};
                    if (last) begin
                        bitcnt <= '0;
                        busy_q <= 1'b0;
                        mst_q  <= 1'b0;
                        rxbuf  <= {shreg[FRAME_W-2:0], rx_bit};
                    end else begin
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                end
                if (!mst_q && !slv_sel) begin
                    busy_q <= 1'b0;
                    bitcnt <= '0;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign mst_run = busy_q && mst_q;
    assign done    = last;
    assign rx_data = rxbuf;
    assign sck_o   = sck_q;
    assign sdo     = shreg[FRAME_W-1];
endmodule

// File: rtl/spi_flags.sv
// Module: status flag sequencer. Holds the transfer-done and collision flags,
// the arming state of the read-then-access clear sequence, and the interrupt.
// Assumes a status read and a data access never occur in the same cycle.
module spi_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_fault,
    input  logic collide,
    input  logic stat_rd,
    input  logic data_acc,
    input  logic ack,
    input  logic irq_en,
    input  logic gie,
    output logic spif,
    output logic wcol,
    output logic irq
);
    logic spif_q, wcol_q, arm_s, arm_w, spif_evt;

    assign spif_evt = set_done || set_fault;

    // Arm each flag's clear when a status read sees it; new events disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_s <= 1'b0;
            arm_w <= 1'b0;
        end else if (stat_rd) begin
            arm_s <= spif_q && !spif_evt;
            arm_w <= wcol_q && !collide;
        end else begin
            if (data_acc || spif_evt) arm_s <= 1'b0;
            if (data_acc || collide)  arm_w <= 1'b0;
        end
    end

    // Set and clear the flags; a set event always wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spif_q <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (spif_evt)                spif_q <= 1'b1;
            else if (ack)                spif_q <= 1'b0;
            else if (data_acc && arm_s)  spif_q <= 1'b0;
            if (collide)                 wcol_q <= 1'b1;
            else if (data_acc && arm_w)  wcol_q <= 1'b0;
        end
    end

    assign spif = spif_q;
    assign wcol = wcol_q;
    assign irq  = spif_q && irq_en && gie;
endmodule

// File: rtl/serial_port_ctl.sv
// Module: serial port controller top. Decodes the register bus, holds the
// control and double-speed bits, detects mode faults on the select input and
// ties the rate timer, shift engine and flag sequencer together.
// Assumes single-cycle read and write strobes on the register bus.
module serial_port_ctl #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       gie_i,
    input  logic       irq_ack_i,
    output logic       irq_o,
    output logic       sck_o,
    output logic       mosi_o,
    input  logic       miso_i,
    input  logic       sck_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic       ss_n_i
);
    import spi_ctl_pkg::*;

    localparam int REG_W = $bits(ctrl_t);

    ctrl_t            ctrl_q;
    logic             dbl_q;
    logic             ss_s, sck_s, mosi_s;
    logic             wr_ctrl, wr_stat, wr_data, stat_rd, data_acc;
    logic             master_w, fault_w, busy_w, mst_run_w, done_w, tick_w;
    logic             spif_w, wcol_w, sdo_w, slv_sel_w;
    logic [REG_W-1:0] rx_w;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ss_n_i, sck_i, mosi_i}),
        .q({ss_s, sck_s, mosi_s})
    );

    assign wr_ctrl   = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_data   = reg_wr && (reg_addr == ADDR_DATA);
    assign stat_rd   = reg_rd && (reg_addr == ADDR_STAT);
    assign data_acc  = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
    assign master_w  = ctrl_q.master;
    assign fault_w   = ctrl_q.enable && master_w && !ss_s;
    assign slv_sel_w = ctrl_q.enable && !master_w && !ss_s;

    // Control register; a mode fault forces the master bit low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
            if (fault_w) ctrl_q.master <= 1'b0;
        end
    end

    // Double-speed bit, the only writable status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       dbl_q <= 1'b0;
        else if (wr_stat) dbl_q <= reg_wdata[0];
    end

    spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(mst_run_w),
        .dbl(dbl_q), .rate(ctrl_q.rate), .tick(tick_w)
    );

    spi_shifter #(.FRAME_W(REG_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.enable), .master(master_w),
        .start_load(wr_data), .load_data(reg_wdata), .tick(tick_w),
        .abort(fault_w), .miso_i(miso_i), .slv_sel(slv_sel_w),
        .slv_sck(sck_s), .slv_mosi(mosi_s), .busy(busy_w),
        .mst_run(mst_run_w), .done(done_w), .rx_data(rx_w),
        .sck_o(sck_o), .sdo(sdo_w)
    );

    spi_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_done(done_w), .set_fault(fault_w),
        .collide(wr_data && busy_w), .stat_rd(stat_rd), .data_acc(data_acc),
        .ack(irq_ack_i), .irq_en(ctrl_q.irq_en), .gie(gie_i),
        .spif(spif_w), .wcol(wcol_w), .irq(irq_o)
    );

    assign mosi_o = sdo_w;
    assign miso_o = sdo_w;

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: reg_rdata = {spif_w, wcol_w, 5'b0, dbl_q};
            ADDR_DATA: reg_rdata = rx_w;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_port_ctl_chk.sv
// Module: property checker for the serial port controller, bound to the top.
// Assumes it sees the top's ports and a few internal handshake signals.
module serial_port_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       gie_i,
    input logic       irq_ack_i,
    input logic       irq_o,
    input logic       sck_o,
    input logic       mosi_o,
    input logic       busy,
    input logic       spif,
    input logic       wcol,
    input logic       master,
    input logic       fault,
    input logic       done
);
    import spi_ctl_pkg::*;

    p_status_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && (reg_addr == ADDR_STAT) |-> reg_rdata[5:1] == 5'b0);

    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck_o);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $rose(sck_o) |-> $stable(mosi_o));

    p_done_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spif);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i && spif);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_i && !done && !fault |=> !spif);

    p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr == ADDR_DATA) && busy |=> wcol);

    p_fault_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !master && spif && !busy);
endmodule

bind serial_port_ctl serial_port_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .gie_i(gie_i),
    .irq_ack_i(irq_ack_i), .irq_o(irq_o), .sck_o(sck_o), .mosi_o(mosi_o),
    .busy(busy_w), .spif(spif_w), .wcol(wcol_w), .master(master_w),
    .fault(fault_w), .done(done_w)
);

// File: tb/serial_port_ctl_test.sv
// Bench: self-checking test of the serial port controller.
module serial_port_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

    // {double speed, rate code, tx byte, expected divisor}
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 2'd0, 8'hA5, 8'd4},   {1'b0, 2'd1, 8'h3C, 8'd16},
        {1'b0, 2'd2, 8'h81, 8'd64},  {1'b0, 2'd3, 8'h7E, 8'd128},
        {1'b1, 2'd0, 8'h5A, 8'd2},   {1'b1, 2'd1, 8'hC3, 8'd8},
        {1'b1, 2'd2, 8'h01, 8'd32},  {1'b1, 2'd3, 8'hF0, 8'd64}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       gie = 1'b0, ack = 1'b0, irq;
    logic       sck_o, mosi_o, miso_o;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n = 1'b1;
    int         checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_port_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gie_i(gie), .irq_ack_i(ack), .irq_o(irq), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(mosi_o), .sck_i(sck_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .ss_n_i(ss_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        cyc(4); rst_n = 1'b1; cyc(1);

        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 sck", sck_o, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
        rd(A_STAT, v); chk("R1 status", v, 8'h00);

        // R2 only bit 0 of status is writable, bits 5:1 read zero
        wr(A_STAT, 8'hFF); rd(A_STAT, v); chk("R2 status write", v, 8'h01);
        wr(A_STAT, 8'h00);

        // R3 R4 R5 R8 divisor table walk with loopback
        gie = 1'b1;
        for (int i = 0; i < 8; i++) begin
            logic       dbl  = VEC[i][18];
            logic [1:0] rate = VEC[i][17:16];
            logic [7:0] tx   = VEC[i][15:8];
            int         d    = int'(VEC[i][7:0]);
            wr(A_STAT, {7'b0, dbl});
            wr(A_CTRL, 8'hC4 | {6'b0, rate});
            wr(A_DATA, tx);
            chk("R4 first bit", mosi_o, tx[7]);
            cyc(d);
            chk("R4 second bit", mosi_o, tx[6]);
            cyc(7 * d - 1);
            chk("R3 not yet done", irq, 0);
            cyc(1);
            chk("R3 R5 done at 8D", irq, 1);
            rd(A_DATA, v);
            chk("R4 received byte", v, tx);
            chk("R8 unarmed access keeps flag", irq, 1);
            rd(A_STAT, v); chk("R5 status", v, {1'b1, 6'b0, dbl});
            rd(A_DATA, v);
            chk("R8 armed access clears", irq, 0);
        end

        // R6 R7 interrupt gating and acknowledge
        wr(A_STAT, 8'h01); wr(A_CTRL, 8'hC4);
        gie = 1'b0;
        wr(A_DATA, 8'h5A); cyc(40);
        chk("R6 gie low", irq, 0);
        gie = 1'b1; cyc(1);
        chk("R6 gie high", irq, 1);
        ack = 1'b1; cyc(1); ack = 1'b0; cyc(1);
        chk("R7 ack clears", irq, 0);

        // R10 collision during a frame
        wr(A_DATA, 8'h96); cyc(4);
        wr(A_DATA, 8'h11); cyc(30);
        rd(A_STAT, v); chk("R10 flags set", v, 8'hC1);
        rd(A_DATA, v); chk("R10 frame intact", v, 8'h96);
        rd(A_STAT, v); chk("R10 R8 both cleared", v, 8'h01);

        // R11 mode fault aborts a slow frame
        wr(A_STAT, 8'h00); wr(A_CTRL, 8'hC7);
        wr(A_DATA, 8'hFF); cyc(20);
        ss_n = 1'b0; cyc(5);
        chk("R11 sck low", sck_o, 0);
        chk("R11 flag set", irq, 1);
        rd(A_CTRL, v); chk("R11 master cleared", v, 8'hC3);
        ss_n = 1'b1; cyc(3);

        // R9 event between arming read and data access survives
        wr(A_CTRL, 8'hC7);
        rd(A_STAT, v); chk("R9 armed with flag", v, 8'h80);
        ss_n = 1'b0; cyc(5); ss_n = 1'b1; cyc(3);
        rd(A_DATA, v);
        chk("R9 flag survives", irq, 1);
        rd(A_STAT, v); rd(A_DATA, v);
        chk("R8 cleared after rearm", irq, 0);

        // R12 slave exchange
        wr(A_CTRL, 8'hC0);
        wr(A_DATA, 8'hA5);
        ss_n = 1'b0; cyc(4);
        for (int b = 7; b >= 0; b--) begin
            mosi_i = v[0] ^ v[0] ^ ((8'h3C >> b) & 1'b1);
            cyc(4);
            chk("R12 slave out bit", miso_o, (8'hA5 >> b) & 1);
            sck_i = 1'b1; cyc(4);
            sck_i = 1'b0; cyc(4);
        end
        cyc(6);
        chk("R12 slave done", irq, 1);
        rd(A_DATA, v); chk("R12 slave rx", v, 8'h3C);
        ss_n = 1'b1; cyc(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule